// File: doc/BRIEF.md
# CEC Destination Address Filter

This block decides, once per incoming CEC frame, whether the node acknowledges the frame and whether it keeps it. When the receiver has assembled the header, it pulses a header-done strobe with the 4-bit destination logical address. The filter compares that address against a 15-bit mask of logical addresses the node owns. It then latches two verdicts: a request to drive the acknowledge slot, and a flag that tells the byte store to keep the message.

Each mask bit stands for one logical address, and the node may own any subset of them. Address 0xF is the broadcast address, and every node always takes broadcast frames. A listen mode lets the node collect frames meant for other nodes without ever acknowledging them. The verdicts stay fixed until an end-of-message strobe clears them or the next header arrives.

Top module: `cec_dest_filter`

## Requirements
- R1: After reset, ack_req and rx_accept are both 0.
- R2: When hdr_done is sampled high with dest_addr = i (0 to 14) and own_mask bit i set, ack_req and rx_accept are both 1 from the next clock edge on.
- R3: When hdr_done is sampled high with dest_addr below 15, the mask bit at that position clear, and listen_en low, ack_req and rx_accept are both 0 after the next edge.
- R4: When hdr_done is sampled high with listen_en high, rx_accept is 1 after the next edge, and ack_req is 1 only if R2 applies.
- R5: A header with dest_addr = 15 (broadcast) gives rx_accept = 1 and ack_req = 0, whatever own_mask and listen_en hold.
- R6: While hdr_done and msg_end are both low, the outputs do not change, even when dest_addr, own_mask or listen_en change.
- R7: msg_end sampled high with hdr_done low clears both outputs at the next edge. When both strobes are high in the same cycle, hdr_done wins and a new verdict is latched.
- R8: ack_req is never 1 while rx_accept is 0.
- R9: With own_mask = 0x0021 only addresses 0 and 5 are acknowledged. With own_mask = 0 no address is acknowledged, but broadcast frames are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_done | input | 1 | One-cycle pulse: the header has been fully received |
| dest_addr | input | 4 | Destination logical address from the header |
| own_mask | input | 15 | Bit i set means the node owns logical address i |
| listen_en | input | 1 | Keep frames for other nodes without acknowledging them |
| msg_end | input | 1 | One-cycle pulse: the current message is finished |
| ack_req | output | 1 | Request to drive the acknowledge slot for this frame |
| rx_accept | output | 1 | Keep the incoming message |

## Verification
Several properties are checked on every cycle: acknowledge implies accept, outputs hold between strobes, broadcast never acknowledges, listen mode always accepts, and a lone end-of-message clears both outputs. Only the bench scenarios can show that the right mask bit was chosen for each address. They also show the exact decodes for the 0x0021 and all-zero masks, and the priority when both strobes coincide. Those scenarios compare every verdict with a model of the requirements, over random headers and fixed corner cases.

// File: rtl/cec_filt_pkg.sv
package cec_filt_pkg;

    // Latched verdict for one frame
    typedef struct packed {
        logic ack;
        logic accept;
    } cec_verdict_t;

endpackage

// File: rtl/cec_addr_decode.sv
module cec_addr_decode #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]       dest_addr,
    input  logic [(2**ADDR_W)-2:0]  own_mask,
    output logic                    owned_hit,
    output logic                    is_bcast
);
    localparam int NUM_OWN = (2**ADDR_W) - 1;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

    logic [NUM_OWN-1:0] hit_vec;

    // One comparator per ownable address; the broadcast code has no mask bit
    for (genvar i = 0; i < NUM_OWN; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(i);
        assign hit_vec[i] = own_mask[i] && (dest_addr == SLOT_ADDR);
    end

    assign owned_hit = |hit_vec;
    assign is_bcast  = (dest_addr == BCAST_ADDR);

endmodule

// File: rtl/cec_frame_decision.sv
module cec_frame_decision
    import cec_filt_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hdr_done,
    input  logic         msg_end,
    input  logic         owned_hit,
    input  logic         is_bcast,
    input  logic         listen_en,
    output cec_verdict_t verdict
);
    cec_verdict_t verdict_d, verdict_q;

    always_comb begin
        verdict_d = verdict_q;
        if (hdr_done) begin
            verdict_d.ack    = owned_hit && !is_bcast;
            verdict_d.accept = owned_hit || is_bcast || listen_en;
        end else if (msg_end) begin
            verdict_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) verdict_q <= '0;
        else        verdict_q <= verdict_d;
    end

    assign verdict = verdict_q;

    AST_ACK_IMPLIES_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_q.ack |-> verdict_q.accept); // R8

endmodule

// File: rtl/cec_dest_filter.sv
module cec_dest_filter
    import cec_filt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hdr_done,
    input  logic [ADDR_W-1:0]       dest_addr,
    input  logic [(2**ADDR_W)-2:0]  own_mask,
    input  logic                    listen_en,
    input  logic                    msg_end,
    output logic                    ack_req,
    output logic                    rx_accept
);
    localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

    logic         owned_hit;
    logic         is_bcast;
    cec_verdict_t verdict;

    cec_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .dest_addr (dest_addr),
        .own_mask  (own_mask),
        .owned_hit (owned_hit),
        .is_bcast  (is_bcast)
    );

    cec_frame_decision u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_done  (hdr_done),
        .msg_end   (msg_end),
        .owned_hit (owned_hit),
        .is_bcast  (is_bcast),
        .listen_en (listen_en),
        .verdict   (verdict)
    );

    assign ack_req   = verdict.ack;
    assign rx_accept = verdict.accept;

    AST_BCAST_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && dest_addr == BCAST_ADDR) |=> (!ack_req && rx_accept)); // R5
    AST_LISTEN_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && listen_en) |=> rx_accept); // R4
    AST_HOLD_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_done && !msg_end) |=> ($stable(ack_req) && $stable(rx_accept))); // R6
    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_end && !hdr_done) |=> (!ack_req && !rx_accept)); // R7

endmodule

// File: tb/sim_cec_dest_filter.sv
module sim_cec_dest_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_done = 1'b0;
    logic [3:0]  dest_addr = '0;
    logic [14:0] own_mask = '0;
    logic        listen_en = 1'b0;
    logic        msg_end = 1'b0;
    logic        ack_req;
    logic        rx_accept;

    int checks = 0;
    int fails  = 0;
    logic exp_a = 1'b0;
    logic exp_r = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    cec_dest_filter u0 (
        .clk(clk), .rst_n(rst_n), .hdr_done(hdr_done), .dest_addr(dest_addr),
        .own_mask(own_mask), .listen_en(listen_en), .msg_end(msg_end),
        .ack_req(ack_req), .rx_accept(rx_accept)
    );

    function automatic logic model_ack(input logic [3:0] d, input logic [14:0] m);
        return (d != 4'hF) && m[d];
    endfunction

    function automatic logic model_acc(input logic [3:0] d, input logic [14:0] m, input logic l);
        return (d == 4'hF) || l || ((d != 4'hF) && m[d]);
    endfunction

    task automatic check(input string req);
        checks++;
        if (ack_req !== exp_a || rx_accept !== exp_r) begin
            fails++;
            $display("FAIL %s: ack=%b acc=%b expected ack=%b acc=%b", req,
                     ack_req, rx_accept, exp_a, exp_r);
        end
    endtask

    // Drive a header pulse at a negedge; the verdict is visible at the following negedge
    task automatic header(input logic [3:0] d, input logic [14:0] m, input logic l,
                          input logic with_end);
        dest_addr = d; own_mask = m; listen_en = l; hdr_done = 1'b1; msg_end = with_end;
        @(negedge clk);
        hdr_done = 1'b0; msg_end = 1'b0;
        exp_a = model_ack(d, m);
        exp_r = model_acc(d, m, l);
    endtask

    task automatic end_msg();
        msg_end = 1'b1;
        @(negedge clk);
        msg_end = 1'b0;
        exp_a = 1'b0; exp_r = 1'b0;
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        header(4'd5, 15'h0021, 1'b0, 1'b0); check("R9");
        header(4'd0, 15'h0021, 1'b0, 1'b0); check("R9");
        header(4'd1, 15'h0021, 1'b0, 1'b0); check("R9");
        header(4'd7, 15'h0000, 1'b0, 1'b0); check("R9");
        header(4'hF, 15'h0000, 1'b0, 1'b0); check("R9");
        header(4'hF, 15'h7FFF, 1'b1, 1'b0); check("R5");
        header(4'd14, 15'h4000, 1'b0, 1'b0); check("R2");
        header(4'd3, 15'h7FF7, 1'b0, 1'b0); check("R3");
        header(4'd3, 15'h0000, 1'b1, 1'b0); check("R4");
        header(4'd2, 15'h0004, 1'b1, 1'b0); check("R4");
        // R6: change inputs with no strobe
        dest_addr = 4'd9; own_mask = 15'h0000; listen_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R6");
        end_msg(); check("R7");
        header(4'd6, 15'h0040, 1'b0, 1'b1); check("R7");

        for (int i = 0; i < 400; i++) begin
            logic [3:0]  d;
            logic [14:0] m;
            logic        l;
            d = 4'($urandom_range(0, 15));
            m = 15'($urandom);
            if ($urandom_range(0, 3) == 0) m = m | (15'd1 << d[3:0]);
            l = 1'($urandom);
            header(d, m, l, 1'($urandom_range(0, 7) == 0));
            if (d == 4'hF) check("R5");
            else if (m[d]) check("R2");
            else if (l) check("R4");
            else check("R3");
            if (exp_a && !exp_r) begin
                checks++; fails++;
                $display("FAIL R8: ack=%b acc=%b expected acc=1", exp_a, exp_r);
            end
            dest_addr = 4'($urandom); own_mask = 15'($urandom); listen_en = 1'($urandom);
            @(negedge clk);
            check("R6");
            if ($urandom_range(0, 1) == 1) begin
                end_msg(); check("R7");
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: ran=timeout expected=finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule